// File: doc/BRIEF.md
# Phased Memory Write-Strobe Generator

This block drives the active-low write strobe of a latch-based memory. The memory's address and data registers load on the rising edge of a system clock. A memory clock runs at exactly four times the system clock rate. The block counts that clock into a phase index, so each system cycle splits into four equal slices numbered 0 to 3. The strobe may only go low in the two middle slices. Address and data therefore settle for a full slice before the strobe falls, and they stay put for a full slice after it rises. When the strobe is high, the memory presents the addressed word on its read port.

The write request comes from the system-clock domain and is sampled once per system cycle, at the memory-clock edge that ends phase 0. The phase counter has to stay aligned with the system clock. To do this, the system clock level is sampled on falling memory-clock edges, and a low-then-high pair of samples marks a system rising edge. A two-state synchroniser tracks alignment:
- **ST_SEEK** moves to **ST_RUN** through the *lock* transition, when a detected rise finds the counter at phase 0.
- **ST_RUN** falls back to **ST_SEEK** through the *slip* transition, when a detected rise finds the counter anywhere else.
- Otherwise each state holds.

Writes are only issued in ST_RUN.

With the default settings the strobe falls at the start of phase 1 and rises at the start of phase 3. At a 1 ns system period with 50 ps register delay, this gives 200 ps of setup and 300 ps of hold, against 150 ps and 180 ps required.

Top module: `phased_we_gen`

## Requirements
- R1: While rst_n is low, mem_we_n is 1 and phase is 0.
- R2: Outside a realignment, phase advances by one on every memory-clock rising edge and wraps from 3 to 0.
- R3: A system-clock rise is detected at the memory edge following two falling-edge samples of sys_clk that read 0 then 1. Both samples reset to 1. Each detected rise loads phase with 1, so once aligned, phase reads 0 during the first memory period of every system cycle.
- R4: In ST_RUN, if wr_req is 1 at the memory edge that ends phase 0, mem_we_n is 0 during phases 1 and 2 of that system cycle and 1 during phases 3 and 0.
- R5: If wr_req is 0 at the memory edge that ends phase 0, mem_we_n stays 1 for the whole system cycle.
- R6: Requests in consecutive system cycles give separate strobes, with mem_we_n back at 1 in phases 3 and 0 between them.
- R7: After reset, writes are suppressed until the lock transition, which needs a detected rise with the counter at phase 0. With reset released 1 ns after a system edge, the first two system cycles issue no strobe and the third does.
- R8: On a slip, mem_we_n is forced to 1 and phase is reloaded to 1. The next system cycle issues no strobe while the lock repeats, and strobes resume in the cycle after that.
- R9: wr_req is ignored at all memory edges other than the one ending phase 0. Raising it after that edge starts no strobe, and dropping it after that edge does not shorten one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_clk | input | 1 | Memory clock, four times the system clock rate |
| sys_clk | input | 1 | System clock; sampled as data to align the phase counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request from the system-clock domain |
| mem_we_n | output | 1 | Active-low memory write strobe |
| phase | output | 2 | Current phase index within the system cycle |

## Verification
The assertions take for granted three things about the inputs:
- Every system rising edge coincides with a memory rising edge, so the system clock is high for the first two phases and low for the last two.
- wr_req changes only away from memory-clock edges.
- Reset is released between edges.

The stimulus derives both clocks from one time base and drives requests 1 ns after a system edge. The only deliberate break in alignment is a single system low half stretched by exactly one memory period, which exercises the slip path.

// File: rtl/phwe_pkg.sv
`timescale 1ns/1ps
package phwe_pkg;

    // Alignment state of the phase counter against the system clock.
    typedef enum logic {
        ST_SEEK = 1'b0,   // not yet aligned: writes blocked
        ST_RUN  = 1'b1    // aligned: writes allowed
    } sync_state_e;

endpackage

// File: rtl/phwe_edge_track.sv
`timescale 1ns/1ps
// Detects system-clock rising edges by sampling its level on the
// falling memory-clock edge (mid-phase, away from any race).
module phwe_edge_track (
    input  logic mem_clk,
    input  logic rst_n,
    input  logic sys_clk,
    output logic sys_rise
);

    logic lvl_now_q;
    logic lvl_old_q;

    always_ff @(negedge mem_clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_now_q <= 1'b1;
            lvl_old_q <= 1'b1;
        end else begin
            lvl_old_q <= lvl_now_q;
            lvl_now_q <= sys_clk;
        end
    end

    assign sys_rise = lvl_now_q & ~lvl_old_q;

    // R3: a detected rise lasts exactly one memory period
    a_r3_single_rise: assert property (@(posedge mem_clk) disable iff (!rst_n)
        sys_rise |=> !sys_rise);

endmodule

// File: rtl/phwe_phase_cnt.sv
`timescale 1ns/1ps
// Phase counter on the memory clock, reloaded on every detected system rise.
module phwe_phase_cnt #(
    parameter int NUM_PHASES = 4,
    localparam int PH_W = $clog2(NUM_PHASES)
) (
    input  logic            mem_clk,
    input  logic            rst_n,
    input  logic            realign,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] LAST_PH   = PH_W'(NUM_PHASES - 1);
    localparam logic [PH_W-1:0] RELOAD_PH = PH_W'(1);

    logic [PH_W-1:0] cnt_q;

    always_ff @(posedge mem_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (realign) begin
            // the rise was seen at the edge ending phase 0
            cnt_q <= RELOAD_PH;
        end else if (cnt_q == LAST_PH) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase = cnt_q;

    // R2: free-running step with wrap
    a_r2_step: assert property (@(posedge mem_clk) disable iff (!rst_n)
        !realign |=> (cnt_q == (($past(cnt_q) == LAST_PH) ? '0 : $past(cnt_q) + 1'b1)));

    // R3: realignment lands on phase 1
    a_r3_reload: assert property (@(posedge mem_clk) disable iff (!rst_n)
        realign |=> (cnt_q == RELOAD_PH));

endmodule

// File: rtl/phwe_sync_fsm.sv
`timescale 1ns/1ps
// Lock / slip state machine.
module phwe_sync_fsm
    import phwe_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic            mem_clk,
    input  logic            rst_n,
    input  logic            sys_rise,
    input  logic [PH_W-1:0] phase,
    output logic            run,
    output logic            slip
);

    sync_state_e state_q;
    sync_state_e state_d;

    logic at_zero;
    assign at_zero = (phase == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK: if (sys_rise && at_zero)  state_d = ST_RUN;   // lock
            ST_RUN:  if (sys_rise && !at_zero) state_d = ST_SEEK;  // slip
        endcase
    end

    always_ff @(posedge mem_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEK;
        else        state_q <= state_d;
    end

    always_comb begin
        run  = (state_q == ST_RUN);
        slip = (state_q == ST_RUN) && sys_rise && !at_zero;
    end

    // R7: lock transition
    a_r7_lock: assert property (@(posedge mem_clk) disable iff (!rst_n)
        (!run && sys_rise && at_zero) |=> run);

    // R8: slip transition
    a_r8_slip_state: assert property (@(posedge mem_clk) disable iff (!rst_n)
        (sys_rise && !at_zero) |=> !run);

endmodule

// File: rtl/phwe_strobe.sv
`timescale 1ns/1ps
// Shapes the active-low write strobe inside one system cycle.
module phwe_strobe #(
    parameter int NUM_PHASES = 4,
    parameter int FALL_PHASE = 1,
    parameter int RISE_PHASE = 3,
    localparam int PH_W = $clog2(NUM_PHASES)
) (
    input  logic            mem_clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            slip,
    input  logic            wr_req,
    input  logic [PH_W-1:0] phase,
    output logic            we_n
);

    // strobe changes at the edge that ends the phase before each boundary
    localparam logic [PH_W-1:0] FALL_PRE = PH_W'(FALL_PHASE - 1);
    localparam logic [PH_W-1:0] RISE_PRE = PH_W'(RISE_PHASE - 1);

    logic we_n_q;

    always_ff @(posedge mem_clk or negedge rst_n) begin
        if (!rst_n) begin
            we_n_q <= 1'b1;
        end else if (!run || slip) begin
            we_n_q <= 1'b1;
        end else if (phase == FALL_PRE) begin
            we_n_q <= ~wr_req;
        end else if (phase == RISE_PRE) begin
            we_n_q <= 1'b1;
        end
    end

    assign we_n = we_n_q;

    // R4: an accepted request pulls the strobe low
    a_r4_fall: assert property (@(posedge mem_clk) disable iff (!rst_n)
        (run && !slip && phase == FALL_PRE && wr_req) |=> !we_n_q);

    // R4: strobe always released at the closing boundary
    a_r4_release: assert property (@(posedge mem_clk) disable iff (!rst_n)
        (phase == RISE_PRE) |=> we_n_q);

    // R5: no request, no strobe
    a_r5_idle: assert property (@(posedge mem_clk) disable iff (!rst_n)
        (phase == FALL_PRE && !wr_req) |=> we_n_q);

    // R7: blocked while unaligned
    a_r7_blocked: assert property (@(posedge mem_clk) disable iff (!rst_n)
        !run |=> we_n_q);

    // R8: slip forces the strobe high
    a_r8_slip_high: assert property (@(posedge mem_clk) disable iff (!rst_n)
        slip |=> we_n_q);

    // R9: request ignored away from the sampling boundary
    a_r9_hold: assert property (@(posedge mem_clk) disable iff (!rst_n)
        (run && !slip && phase != FALL_PRE && phase != RISE_PRE) |=> $stable(we_n_q));

endmodule

// File: rtl/phased_we_gen.sv
`timescale 1ns/1ps
module phased_we_gen #(
    parameter int NUM_PHASES = 4,
    parameter int FALL_PHASE = 1,
    parameter int RISE_PHASE = 3,
    localparam int PH_W = $clog2(NUM_PHASES)
) (
    input  logic            mem_clk,
    input  logic            sys_clk,
    input  logic            rst_n,
    input  logic            wr_req,
    output logic            mem_we_n,
    output logic [PH_W-1:0] phase
);

    logic sys_rise;
    logic run;
    logic slip;

    phwe_edge_track u_edge (
        .mem_clk  (mem_clk),
        .rst_n    (rst_n),
        .sys_clk  (sys_clk),
        .sys_rise (sys_rise)
    );

    phwe_phase_cnt #(
        .NUM_PHASES (NUM_PHASES)
    ) u_cnt (
        .mem_clk (mem_clk),
        .rst_n   (rst_n),
        .realign (sys_rise),
        .phase   (phase)
    );

    phwe_sync_fsm #(
        .PH_W (PH_W)
    ) u_fsm (
        .mem_clk  (mem_clk),
        .rst_n    (rst_n),
        .sys_rise (sys_rise),
        .phase    (phase),
        .run      (run),
        .slip     (slip)
    );

    phwe_strobe #(
        .NUM_PHASES (NUM_PHASES),
        .FALL_PHASE (FALL_PHASE),
        .RISE_PHASE (RISE_PHASE)
    ) u_strobe (
        .mem_clk (mem_clk),
        .rst_n   (rst_n),
        .run     (run),
        .slip    (slip),
        .wr_req  (wr_req),
        .phase   (phase),
        .we_n    (mem_we_n)
    );

    // R4: strobe low only inside the middle window
    a_r4_window: assert property (@(posedge mem_clk) disable iff (!rst_n)
        !mem_we_n |-> (phase >= PH_W'(FALL_PHASE) && phase < PH_W'(RISE_PHASE)));

    // R1: idle outputs while in reset (checked mid-period)
    always @(negedge mem_clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (mem_we_n && phase == '0);
        end
    end

endmodule

// File: tb/phased_we_gen_tb.sv
`timescale 1ns/1ps
module phased_we_gen_tb;

    logic       mem_clk;
    logic       sys_clk;
    logic       rst_n;
    logic       wr_req;
    logic       mem_we_n;
    logic [1:0] phase;

    int n_checks = 0;
    int n_errors = 0;
    bit slip_req = 0;
    bit done     = 0;

    phased_we_gen u_dut (
        .mem_clk  (mem_clk),
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .mem_we_n (mem_we_n),
        .phase    (phase)
    );

    // memory clock: 5 ns period, rising edges at 2.5 + 5k
    initial begin
        mem_clk = 1'b0;
        forever #2.5 mem_clk = ~mem_clk;
    end

    // 50 MHz system clock, rising with a memory rising edge;
    // slip_req stretches one low half by one memory period
    initial begin
        sys_clk = 1'b0;
        #2.5;
        forever begin
            sys_clk = 1'b1;
            #10;
            sys_clk = 1'b0;
            #10;
            if (slip_req) begin
                slip_req = 1'b0;
                #5;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout, expected completion");
            summary();
            $finish;
        end
    end

    task automatic check_val(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    // start a system cycle: wait for its edge, drive request 1 ns later
    task automatic next_cycle(logic req);
        @(posedge sys_clk);
        #1;
        wr_req = req;
    endtask

    // called at edge+1; samples mid-phase k at edge+2.5+5k.
    // exp_we[k] is the expected strobe in phase k.
    task automatic check_cycle(string req, logic [3:0] exp_we, logic [3:0] we_mask,
                               bit chk_ph, bit late_en, logic late_val);
        for (int k = 0; k < 4; k++) begin
            if (k == 0) begin
                #1.5;
            end else if (k == 1) begin
                #3.5;
                if (late_en) wr_req = late_val;
                #1.5;
            end else begin
                #5;
            end
            if (we_mask[k]) check_val(req, "mem_we_n", int'(mem_we_n), int'(exp_we[k]));
            if (chk_ph)     check_val(req, "phase", int'(phase), k);
        end
    endtask

    task automatic t_reset();
        #30;
        check_val("R1", "mem_we_n", int'(mem_we_n), 1);
        check_val("R1", "phase", int'(phase), 0);
    endtask

    // R7: no strobe before lock, then strobe
    task automatic t_lockout();
        next_cycle(1'b1);
        rst_n = 1'b1;
        check_cycle("R7", 4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0);
        next_cycle(1'b1);
        check_cycle("R7", 4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0);
        check_val("R2", "phase after wrap", int'(phase), 3);
        next_cycle(1'b1);
        check_cycle("R4", 4'b1001, 4'b1111, 1'b1, 1'b0, 1'b0);
    endtask

    // R6: consecutive and interleaved requests
    task automatic t_burst();
        next_cycle(1'b1);
        check_cycle("R6", 4'b1001, 4'b1111, 1'b0, 1'b0, 1'b0);
        next_cycle(1'b1);
        check_cycle("R6", 4'b1001, 4'b1111, 1'b1, 1'b0, 1'b0);
        next_cycle(1'b0);
        check_cycle("R5", 4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0);
        next_cycle(1'b1);
        check_cycle("R6", 4'b1001, 4'b1111, 1'b0, 1'b0, 1'b0);
    endtask

    // R5: reads only
    task automatic t_read();
        next_cycle(1'b0);
        check_cycle("R5", 4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0);
        next_cycle(1'b0);
        check_cycle("R3", 4'b1111, 4'b1111, 1'b1, 1'b0, 1'b0);
    endtask

    // R9: request sampled only at the end of phase 0
    task automatic t_req_timing();
        next_cycle(1'b0);
        check_cycle("R9", 4'b1111, 4'b1111, 1'b0, 1'b1, 1'b1);  // late rise
        next_cycle(1'b1);
        check_cycle("R9", 4'b1001, 4'b1111, 1'b0, 1'b1, 1'b0);  // late drop
        next_cycle(1'b0);
        check_cycle("R9", 4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0);
    endtask

    // R8: stretched system cycle causes slip, relock, recovery
    task automatic t_slip();
        next_cycle(1'b1);
        slip_req = 1'b1;
        check_cycle("R4", 4'b1001, 4'b1111, 1'b1, 1'b0, 1'b0);
        next_cycle(1'b1);
        check_cycle("R8", 4'b1110, 4'b1110, 1'b0, 1'b0, 1'b0);
        next_cycle(1'b1);
        check_cycle("R8", 4'b1111, 4'b1111, 1'b1, 1'b0, 1'b0);
        next_cycle(1'b1);
        check_cycle("R8", 4'b1001, 4'b1111, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        rst_n  = 1'b0;
        wr_req = 1'b0;
        t_reset();
        t_lockout();
        t_burst();
        t_read();
        t_req_timing();
        t_slip();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule